// File: doc/BRIEF.md
# Iterative HI/LO Multiply-Divide Unit

This block performs integer multiplication and division next to a processor pipeline. It keeps its results in two dedicated result registers, HI and LO, and not in the general register file. A one-cycle start pulse carries a 2-bit operation code and two operands. The unit then iterates one bit per cycle while `busy_o` is high, and writes HI and LO together in the cycle that `done_o` pulses.

A multiply leaves the upper half of the double-width product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI. Each of the two results has its own read port, one for a move-from-HI and one for a move-from-LO. A read request made while the unit is iterating returns a stall indication and no data, so that the requesting stage waits.

A divide whose divisor is zero still runs for its full length and pulses `done_o`. It leaves HI and LO unchanged and sets a flag that stays set until reset.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: Operation code 2'b00 (signed multiply) leaves the signed two's-complement product of `opa_i` and `opb_i`, 2W bits wide, with bits 2W-1..W in HI and bits W-1..0 in LO.
- R2: Operation code 2'b01 (unsigned multiply) leaves the unsigned 2W-bit product, split the same way as in R1.
- R3: Operation code 2'b10 (signed divide) leaves in LO the quotient truncated toward zero, kept to W bits. It leaves in HI the remainder, which carries the sign of the dividend.
- R4: Operation code 2'b11 (unsigned divide) leaves the unsigned quotient in LO and the unsigned remainder in HI.
- R5: A divide (code 2'b10 or 2'b11) with `opb_i` equal to zero leaves HI and LO unchanged. It still pulses `done_o`, and it sets `divz_o`. Once set, `divz_o` stays high until reset.
- R6: A start pulse sampled while idle raises `busy_o` for exactly W cycles. In the clock edge that lowers `busy_o`, `done_o` rises for one cycle and HI and LO take their new values. A new start may be accepted in that same cycle.
- R7: A start pulse sampled while `busy_o` is high is ignored. The running operation finishes with its own operands, and no extra operation follows.
- R8: While idle, a requested port returns its register (`hi_rdata_o` = HI, `lo_rdata_o` = LO) with `rd_stall_o` low. A port that is not requested returns zero.
- R9: A read request on either port while `busy_o` is high raises `rd_stall_o` and returns zero on both data ports. `rd_stall_o` is never high while idle.
- R10: After reset, `busy_o`, `done_o`, `divz_o` and `rd_stall_o` are low, and HI and LO read as zero.
- R11: HI and LO change only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled at the rising edge |
| op_i | input | 2 | Operation code: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa_i | input | W | Multiplicand or dividend |
| opb_i | input | W | Multiplier or divisor |
| busy_o | output | 1 | High while an operation iterates |
| done_o | output | 1 | One-cycle completion pulse |
| divz_o | output | 1 | Sticky divide-by-zero flag |
| hi_rd_i | input | 1 | Move-from-HI request |
| hi_rdata_o | output | W | HI contents when read and idle, else zero |
| lo_rd_i | input | 1 | Move-from-LO request |
| lo_rdata_o | output | W | LO contents when read and idle, else zero |
| rd_stall_o | output | 1 | Read request made while busy |

## Verification
Two functions meet in the completion cycle. In that cycle a new start can be accepted, and the newly written HI and LO must already be readable. The bench holds both read requests high across a full sweep and issues every next operation in the very cycle that `done_o` is seen. So each result read coincides with a new start, and the bench then requires the stall to rise at once for the new operation. A correct unit delivers the fresh result unstalled in the done cycle, the stall in the next cycle, and the exact W-cycle busy window of the following operation.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } md_op_e;

  function automatic logic op_is_div(input md_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_signed(input md_op_e op);
    return ~op[0];
  endfunction
endpackage

// File: rtl/hilo_seq_ctrl.sv
module hilo_seq_ctrl #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic step_o,
  output logic finish_o
);
  localparam int CW = $clog2(W + 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    load_o   = start_i & ~busy_q;
    step_o   = busy_q;
    finish_o = busy_q & (cnt_q == CW'(1));
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    done_d   = finish_o;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = CW'(W);
    end else if (busy_q) begin
      cnt_d = cnt_q - CW'(1);
      if (finish_o) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/hilo_mul_core.sv
module hilo_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_nxt_o
);
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] mq_q, mq_d;
  logic [W-1:0] mcand_q, mcand_d;
  logic [W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + (mq_q[0] ? {1'b0, mcand_q} : '0);
    acc_d   = acc_q;
    mq_d    = mq_q;
    mcand_d = mcand_q;
    if (load_i) begin
      acc_d   = '0;
      mq_d    = a_i;
      mcand_d = b_i;
    end else if (step_i) begin
      acc_d = sum[W:1];
      mq_d  = {sum[0], mq_q[W-1:1]};
    end
    prod_nxt_o = {sum[W:1], sum[0], mq_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mq_q    <= '0;
      mcand_q <= '0;
    end else if (load_i | step_i) begin
      acc_q   <= acc_d;
      mq_q    <= mq_d;
      mcand_q <= mcand_d;
    end
  end
endmodule

// File: rtl/hilo_div_core.sv
module hilo_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] quo_nxt_o,
  output logic [W-1:0] rem_nxt_o
);
  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] dvs_q, dvs_d;
  logic [W:0]   shifted;
  logic [W:0]   diff;
  logic         fits;

  always_comb begin
    shifted   = {rem_q, quo_q[W-1]};
    diff      = shifted - {1'b0, dvs_q};
    fits      = ~diff[W];
    rem_nxt_o = fits ? diff[W-1:0] : shifted[W-1:0];
    quo_nxt_o = {quo_q[W-2:0], fits};
    rem_d     = rem_q;
    quo_d     = quo_q;
    dvs_d     = dvs_q;
    if (load_i) begin
      rem_d = '0;
      quo_d = a_i;
      dvs_d = b_i;
    end else if (step_i) begin
      rem_d = rem_nxt_o;
      quo_d = quo_nxt_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i | step_i) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
    end
  end
endmodule

// File: rtl/hilo_rd_port.sv
module hilo_rd_port #(
  parameter int W = 32
) (
  input  logic         busy_i,
  input  logic         req_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] data_o,
  output logic         stall_o
);
  always_comb begin
    stall_o = req_i & busy_i;
    data_o  = (req_i & ~busy_i) ? val_i : '0;
  end
endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         divz_o,
  input  logic         hi_rd_i,
  output logic [W-1:0] hi_rdata_o,
  input  logic         lo_rd_i,
  output logic [W-1:0] lo_rdata_o,
  output logic         rd_stall_o
);
  localparam int PW = 2 * W;

  logic load, step, finish;
  md_op_e op_in, op_q, op_d;
  logic pneg_q, pneg_d, rneg_q, rneg_d, dzp_q, dzp_d;
  logic a_neg, b_neg;
  logic [W-1:0] a_mag, b_mag;
  logic [PW-1:0] prod_nxt, prod_fix;
  logic [W-1:0] quo_nxt, rem_nxt, quo_fix, rem_fix;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d, hi_new, lo_new;
  logic dz_q, dz_d, wr_en;
  logic hi_stall, lo_stall;

  hilo_seq_ctrl #(.W(W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o),
    .load_o(load), .step_o(step), .finish_o(finish)
  );

  always_comb begin
    op_in  = md_op_e'(op_i);
    a_neg  = op_is_signed(op_in) & opa_i[W-1];
    b_neg  = op_is_signed(op_in) & opb_i[W-1];
    a_mag  = a_neg ? (W'(0) - opa_i) : opa_i;
    b_mag  = b_neg ? (W'(0) - opb_i) : opb_i;
    op_d   = load ? op_in : op_q;
    pneg_d = load ? (a_neg ^ b_neg) : pneg_q;
    rneg_d = load ? a_neg : rneg_q;
    dzp_d  = load ? (op_is_div(op_in) & (opb_i == '0)) : dzp_q;
  end

  hilo_mul_core #(.W(W)) i_mul (
    .clk(clk), .rst_n(rst_n),
    .load_i(load & ~op_is_div(op_in)),
    .step_i(step & ~op_is_div(op_q)),
    .a_i(a_mag), .b_i(b_mag),
    .prod_nxt_o(prod_nxt)
  );

  hilo_div_core #(.W(W)) i_div (
    .clk(clk), .rst_n(rst_n),
    .load_i(load & op_is_div(op_in)),
    .step_i(step & op_is_div(op_q)),
    .a_i(a_mag), .b_i(b_mag),
    .quo_nxt_o(quo_nxt), .rem_nxt_o(rem_nxt)
  );

  always_comb begin
    prod_fix = pneg_q ? (PW'(0) - prod_nxt) : prod_nxt;
    quo_fix  = pneg_q ? (W'(0) - quo_nxt) : quo_nxt;
    rem_fix  = rneg_q ? (W'(0) - rem_nxt) : rem_nxt;
    hi_new   = op_is_div(op_q) ? rem_fix : prod_fix[PW-1:W];
    lo_new   = op_is_div(op_q) ? quo_fix : prod_fix[W-1:0];
    wr_en    = finish & ~(op_is_div(op_q) & dzp_q);
    hi_d     = wr_en ? hi_new : hi_q;
    lo_d     = wr_en ? lo_new : lo_q;
    dz_d     = dz_q | (finish & op_is_div(op_q) & dzp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_MUL_S;
      pneg_q <= 1'b0;
      rneg_q <= 1'b0;
      dzp_q  <= 1'b0;
    end else if (load) begin
      op_q   <= op_d;
      pneg_q <= pneg_d;
      rneg_q <= rneg_d;
      dzp_q  <= dzp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      dz_q <= 1'b0;
    end else if (finish) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      dz_q <= dz_d;
    end
  end

  hilo_rd_port #(.W(W)) i_hi_port (
    .busy_i(busy_o), .req_i(hi_rd_i), .val_i(hi_q),
    .data_o(hi_rdata_o), .stall_o(hi_stall)
  );

  hilo_rd_port #(.W(W)) i_lo_port (
    .busy_i(busy_o), .req_i(lo_rd_i), .val_i(lo_q),
    .data_o(lo_rdata_o), .stall_o(lo_stall)
  );

  assign rd_stall_o = hi_stall | lo_stall;
  assign divz_o     = dz_q;
endmodule

// File: rtl/hilo_muldiv_checker.sv
module hilo_muldiv_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         divz_o,
  input logic         hi_rd_i,
  input logic         lo_rd_i,
  input logic         rd_stall_o,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int CW = $clog2(W + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (busy_o) run_q <= run_q + CW'(1);
    else run_q <= '0;
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R6
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_q == CW'(W))); // R6
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_q < CW'(W))); // R7
  AST_STALL_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_rd_i || lo_rd_i) && busy_o) |-> rd_stall_o); // R9
  AST_NO_IDLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall_o |-> busy_o); // R9
  AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(hi_q) && $stable(lo_q))); // R11
  AST_DIVZ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    divz_o |=> divz_o); // R5
  AST_DIVZ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(divz_o) |-> (done_o && $stable(hi_q) && $stable(lo_q))); // R5
endmodule

bind hilo_muldiv_unit hilo_muldiv_checker #(.W(W)) i_hilo_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .divz_o(divz_o), .hi_rd_i(hi_rd_i), .lo_rd_i(lo_rd_i),
  .rd_stall_o(rd_stall_o), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/test_hilo_muldiv_unit.sv
module test_hilo_muldiv_unit;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [1:0] op;
  logic [W-1:0] opa, opb;
  logic busy, done, divz, hi_rd, lo_rd, stall;
  logic [W-1:0] hi_data, lo_data;

  int nchk = 0;
  int nfail = 0;
  int exp_hi = 0;
  int exp_lo = 0;
  bit exp_dz = 1'b0;

  always #5 clk = ~clk;

  hilo_muldiv_unit #(.W(W)) i_hilo_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .opa_i(opa), .opb_i(opb), .busy_o(busy), .done_o(done),
    .divz_o(divz), .hi_rd_i(hi_rd), .hi_rdata_o(hi_data),
    .lo_rd_i(lo_rd), .lo_rdata_o(lo_data), .rd_stall_o(stall)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int sx(input int v);
    return (v > M / 2) ? v - (M + 1) : v;
  endfunction

  task automatic model(input int o, input int a, input int b);
    int p, q, r;
    case (o)
      0: begin p = sx(a) * sx(b); exp_hi = (p >> W) & M; exp_lo = p & M; end
      1: begin p = a * b; exp_hi = (p >> W) & M; exp_lo = p & M; end
      default: begin
        if (b == 0) exp_dz = 1'b1;
        else begin
          if (o == 2) begin q = sx(a) / sx(b); r = sx(a) % sx(b); end
          else begin q = a / b; r = a % b; end
          exp_hi = r & M;
          exp_lo = q & M;
        end
      end
    endcase
  endtask

  // Starts at a negedge and returns at the negedge of the done cycle.
  task automatic run_op(input int o, input int a, input int b);
    int nb = 0;
    bit bad = 1'b0;
    string tag;
    start = 1'b1; op = 2'(o); opa = W'(a); opb = W'(b);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= W; k++) begin
      if (busy) nb++;
      if (done || !stall || hi_data != 0 || lo_data != 0) bad = 1'b1;
      if (k < W) @(negedge clk);
    end
    @(negedge clk);
    model(o, a, b);
    chk(nb == W && done && !busy, "R6 busy window/done", nb, W);
    chk(!bad, "R9 stall while busy", int'(bad), 0);
    tag = (o == 0) ? "R1" : (o == 1) ? "R2" : (o == 2) ? "R3" : "R4";
    if (o >= 2 && b == 0) tag = "R5";
    chk(!stall && hi_data == W'(exp_hi) && lo_data == W'(exp_lo),
        {tag, " HI:LO / R8 read"}, {hi_data, lo_data}, (exp_hi << W) | exp_lo);
    chk(divz == exp_dz, "R5 div-by-zero flag", int'(divz), int'(exp_dz));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int dn;
    rst_n = 1'b0; start = 1'b0; op = '0; opa = '0; opb = '0;
    hi_rd = 1'b1; lo_rd = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !divz && !stall, "R10 reset flags",
        {busy, done, divz, stall}, 0);
    chk(hi_data == 0 && lo_data == 0, "R10 reset HI/LO", {hi_data, lo_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Exhaustive sweep; each op starts in the done cycle of the previous one.
    for (int o = 0; o < 4; o++)
      for (int a = 0; a <= M; a++)
        for (int b = 0; b <= M; b++)
          run_op(o, a, b);

    // R11: results hold while idle.
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(hi_data == W'(exp_hi) && lo_data == W'(exp_lo) && !done, "R11 hold",
        {hi_data, lo_data}, (exp_hi << W) | exp_lo);

    // R8: an unrequested port returns zero.
    hi_rd = 1'b0; lo_rd = 1'b0;
    @(negedge clk);
    chk(hi_data == 0 && lo_data == 0 && !stall, "R8 no request",
        {hi_data, lo_data}, 0);
    hi_rd = 1'b1; lo_rd = 1'b1;

    // R7: start held during busy is ignored.
    start = 1'b1; op = 2'b01; opa = W'(3); opb = W'(5);
    @(negedge clk);
    op = 2'b11; opa = W'(M); opb = W'(1);
    dn = 0;
    for (int k = 1; k <= W; k++) begin
      if (k == W) start = 1'b0;
      if (done) dn++;
      @(negedge clk);
    end
    if (done) dn++;
    chk(hi_data == 0 && lo_data == W'(15), "R7 first op result",
        {hi_data, lo_data}, 15);
    repeat (2) begin
      @(negedge clk);
      if (done || busy) dn++;
    end
    chk(dn == 1, "R7 no extra op", dn, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule